// File: doc/BRIEF.md
# Branch Redirect and Squash Controller

This block is the front-end control for a four-stage in-order pipeline (fetch, decode, execute, writeback). It owns the fetch program counter and always moves on to the next sequential address. In effect this predicts every conditional branch as not taken. An unconditional jump is seen in decode and steers fetch to the jump target. A conditional branch is settled in execute. If it is taken, fetch restarts at the branch target. Whenever fetch is redirected, the block discards the younger instructions already fetched down the wrong path. It also keeps a running count of the slots it discarded.

Instruction tags come in as a valid/ready stream. Each cycle, the instruction memory presents the valid bit and kind of the word at `fetch_pc_o`. A tag is consumed only on a cycle where both `ins_valid_i` and `ins_ready_o` are high. When `ins_ready_o` is low, the source must keep the tag where it is, and the fetch address does not move. When `ins_valid_i` is low and the block is ready, an empty slot enters decode and the address does not advance. The stall input freezes the whole front end. Any branch outcome or jump target seen on the first stalled cycle is kept and applied when the stall is released.

The resulting cost of each kind of control transfer is as follows. A jump costs one discarded slot. A taken branch costs two. A branch that is not taken costs none.

Top module: `branch_redirect_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `fetch_pc_o` equals START_PC, all stage valid outputs are 0 and `bubble_cnt_o` is 0.
- R2: With no stall and no redirect, a consumed tag moves `fetch_pc_o` on by 4 on the next cycle. A cycle with `ins_valid_i` low leaves `fetch_pc_o` unchanged and sends an empty slot into decode.
- R3: A valid decode slot of kind 1 (jump) asserts `kill_fetch_o`. On the next cycle `fetch_pc_o` equals `jmp_target_i` and `id_valid_o` is 0. The penalty is one bubble.
- R4: A valid execute slot of kind 2 (branch) with `br_taken_i` high asserts both `kill_fetch_o` and `kill_dec_o`. On the next cycle `fetch_pc_o` equals `br_target_i` and both `id_valid_o` and `ex_valid_o` are 0. The penalty is two bubbles.
- R5: A branch in execute with `br_taken_i` low kills nothing, lets fetch continue sequentially and leaves `bubble_cnt_o` unchanged.
- R6: When a taken branch is in execute and a jump is in decode on the same cycle, the next `fetch_pc_o` is the branch target and the jump is discarded.
- R7: `wb_valid_o` is high only for an instruction that was valid in execute on the previous advancing cycle, so a discarded instruction never reaches writeback.
- R8: While `stall_i` is high, `ins_ready_o` and both kill outputs are 0, and `fetch_pc_o`, all stage valids, the stage kinds and `bubble_cnt_o` hold.
- R9: The values of `br_taken_i`, `br_target_i` and `jmp_target_i` on the first cycle of a stall are the ones applied on the release cycle. Changes to them later in the stall have no effect.
- R10: Kind codes are 0 plain, 1 jump, 2 branch and 3 reserved. A reserved kind behaves as plain. `id_kind_o` and `ex_kind_o` show the code held in each stage.
- R11: `bubble_cnt_o` adds 1 for each valid slot discarded on an advancing cycle, and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Freeze the front end |
| fetch_pc_o | output | ADDR_W | Address being fetched |
| ins_valid_i | input | 1 | Tag for fetch_pc_o is present |
| ins_kind_i | input | 2 | Kind of the fetched instruction |
| ins_ready_o | output | 1 | Tag is consumed this cycle |
| jmp_target_i | input | ADDR_W | Target of the jump in decode |
| br_taken_i | input | 1 | Outcome of the branch in execute |
| br_target_i | input | ADDR_W | Target of the branch in execute |
| id_valid_o | output | 1 | Decode slot valid |
| ex_valid_o | output | 1 | Execute slot valid |
| wb_valid_o | output | 1 | Writeback slot valid |
| id_kind_o | output | 2 | Kind in decode |
| ex_kind_o | output | 2 | Kind in execute |
| kill_fetch_o | output | 1 | Fetch slot discarded this cycle |
| kill_dec_o | output | 1 | Decode slot discarded this cycle |
| bubble_cnt_o | output | CNT_W | Discarded-slot count |

## Verification
A wrong kill decision shows up at once, on the same cycle, at the kill outputs. One cycle later it is also visible as a wrong fetch address, a stage valid bit that is wrong, or a counter that has moved by the wrong amount. A corrupted valid or kind in one stage passes into the next stage on each advancing cycle and reaches writeback within two cycles. A lost outcome hold shows as a wrong address on the release cycle. The bench's reference model is compared against every output on every cycle, so each of these faults is reported within one or two cycles of the cause.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    K_PLAIN  = 2'd0,
    K_JUMP   = 2'd1,
    K_BRANCH = 2'd2,
    K_RSVD   = 2'd3
  } ikind_e;

  typedef struct packed {
    logic   v;
    ikind_e k;
  } slot_t;
endpackage

// File: rtl/brc_pc_gen.sv
module brc_pc_gen #(
  parameter int ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] START_PC = '0,
  parameter int STEP_B   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              seq_step,
  input  logic              take_br,
  input  logic [ADDR_W-1:0] br_tgt,
  input  logic              take_jmp,
  input  logic [ADDR_W-1:0] jmp_tgt,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_B);

  logic [ADDR_W-1:0] pc_q, pc_n;

  always_comb begin
    if (take_br)       pc_n = br_tgt;
    else if (take_jmp) pc_n = jmp_tgt;
    else if (seq_step) pc_n = pc_q + STEP;
    else               pc_n = pc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   pc_q <= START_PC;
    else if (adv) pc_q <= pc_n;
  end

  assign pc_o = pc_q;

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pc_q));
endmodule

// File: rtl/brc_outcome_hold.sv
module brc_outcome_hold #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] br_tgt_i,
  input  logic [ADDR_W-1:0] jmp_tgt_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] br_tgt_o,
  output logic [ADDR_W-1:0] jmp_tgt_o
);
  logic              hold_v;
  logic              h_taken;
  logic [ADDR_W-1:0] h_br, h_jmp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v  <= 1'b0;
      h_taken <= 1'b0;
      h_br    <= '0;
      h_jmp   <= '0;
    end else if (stall && !hold_v) begin
      hold_v  <= 1'b1;
      h_taken <= taken_i;
      h_br    <= br_tgt_i;
      h_jmp   <= jmp_tgt_i;
    end else if (!stall) begin
      hold_v  <= 1'b0;
    end
  end

  assign taken_o   = hold_v ? h_taken : taken_i;
  assign br_tgt_o  = hold_v ? h_br    : br_tgt_i;
  assign jmp_tgt_o = hold_v ? h_jmp   : jmp_tgt_i;

  // R9
  held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && hold_v) |=> ($stable(h_taken) && $stable(h_br) && $stable(h_jmp)));
endmodule

// File: rtl/brc_stage_pipe.sv
module brc_stage_pipe
  import brc_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  slot_t               in_slot,
  input  logic [DEPTH-1:0]    squash,
  output slot_t [DEPTH-1:0]   st_o
);
  slot_t [DEPTH-1:0] src;
  slot_t [DEPTH-1:0] st_q;

  assign src[0] = in_slot;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i > 0) begin : g_link
      assign src[i] = st_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[i].v <= 1'b0;
        st_q[i].k <= K_PLAIN;
      end else if (adv) begin
        st_q[i].v <= src[i].v & ~squash[i];
        st_q[i].k <= src[i].k;
      end
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/brc_bubble_cnt.sv
module brc_bubble_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [1:0]       n_sq,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + CNT_W'(n_sq);
  end

  assign cnt_o = cnt_q;

  // R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(2)));
endmodule

// File: rtl/branch_redirect_ctrl.sv
module branch_redirect_ctrl
  import brc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter logic [ADDR_W-1:0] START_PC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  input  logic              ins_valid_i,
  input  logic [1:0]        ins_kind_i,
  output logic              ins_ready_o,
  input  logic [ADDR_W-1:0] jmp_target_i,
  input  logic              br_taken_i,
  input  logic [ADDR_W-1:0] br_target_i,
  output logic              id_valid_o,
  output logic              ex_valid_o,
  output logic              wb_valid_o,
  output logic [1:0]        id_kind_o,
  output logic [1:0]        ex_kind_o,
  output logic              kill_fetch_o,
  output logic              kill_dec_o,
  output logic [CNT_W-1:0]  bubble_cnt_o
);
  localparam int NSTG = 3;
  localparam int S_ID = 0;
  localparam int S_EX = 1;
  localparam int S_WB = 2;

  logic              go;
  logic              eff_taken;
  logic [ADDR_W-1:0] eff_br, eff_jmp;
  logic              take_br, take_jmp;
  slot_t             in_slot;
  slot_t [NSTG-1:0]  st;
  logic [NSTG-1:0]   squash;
  logic [1:0]        n_sq;

  assign go = !stall_i;

  brc_outcome_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .stall(stall_i),
    .taken_i(br_taken_i), .br_tgt_i(br_target_i), .jmp_tgt_i(jmp_target_i),
    .taken_o(eff_taken), .br_tgt_o(eff_br), .jmp_tgt_o(eff_jmp)
  );

  assign take_br  = st[S_EX].v && (st[S_EX].k == K_BRANCH) && eff_taken;
  assign take_jmp = st[S_ID].v && (st[S_ID].k == K_JUMP) && !take_br;

  assign in_slot.v = ins_valid_i;
  assign in_slot.k = ikind_e'(ins_kind_i);

  assign squash[S_ID] = take_br | take_jmp;
  assign squash[S_EX] = take_br;
  assign squash[S_WB] = 1'b0;

  assign n_sq = {1'b0, ins_valid_i & (take_br | take_jmp)}
              + {1'b0, st[S_ID].v & take_br};

  brc_pc_gen #(.ADDR_W(ADDR_W), .START_PC(START_PC), .STEP_B(4)) u_pc (
    .clk(clk), .rst_n(rst_n), .adv(go), .seq_step(ins_valid_i),
    .take_br(take_br), .br_tgt(eff_br),
    .take_jmp(take_jmp), .jmp_tgt(eff_jmp),
    .pc_o(fetch_pc_o)
  );

  brc_stage_pipe #(.DEPTH(NSTG)) u_pipe (
    .clk(clk), .rst_n(rst_n), .adv(go),
    .in_slot(in_slot), .squash(squash), .st_o(st)
  );

  brc_bubble_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(go), .n_sq(n_sq), .cnt_o(bubble_cnt_o)
  );

  assign ins_ready_o  = go;
  assign kill_fetch_o = go & (take_br | take_jmp);
  assign kill_dec_o   = go & take_br;
  assign id_valid_o   = st[S_ID].v;
  assign ex_valid_o   = st[S_EX].v;
  assign wb_valid_o   = st[S_WB].v;
  assign id_kind_o    = st[S_ID].k;
  assign ex_kind_o    = st[S_EX].k;

  // R3
  fetch_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_fetch_o |=> !id_valid_o);

  // R4
  dec_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_dec_o |=> (!ex_valid_o && !id_valid_o));

  // R8
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(id_valid_o) && $stable(ex_valid_o) && $stable(wb_valid_o)
                 && $stable(bubble_cnt_o)));

  // R7
  wb_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !ex_valid_o) |=> !wb_valid_o);
endmodule

// File: tb/tb_branch_redirect_ctrl.sv
`timescale 1ns/100ps
module tb_branch_redirect_ctrl;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam logic [AW-1:0] SPC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall_i = 1'b0;
  logic [AW-1:0] fetch_pc_o;
  logic ins_valid_i = 1'b0;
  logic [1:0] ins_kind_i = 2'd0;
  logic ins_ready_o;
  logic [AW-1:0] jmp_target_i = '0;
  logic br_taken_i = 1'b0;
  logic [AW-1:0] br_target_i = '0;
  logic id_valid_o, ex_valid_o, wb_valid_o;
  logic [1:0] id_kind_o, ex_kind_o;
  logic kill_fetch_o, kill_dec_o;
  logic [CW-1:0] bubble_cnt_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  branch_redirect_ctrl #(.ADDR_W(AW), .CNT_W(CW), .START_PC(SPC)) dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .fetch_pc_o(fetch_pc_o),
    .ins_valid_i(ins_valid_i), .ins_kind_i(ins_kind_i), .ins_ready_o(ins_ready_o),
    .jmp_target_i(jmp_target_i), .br_taken_i(br_taken_i), .br_target_i(br_target_i),
    .id_valid_o(id_valid_o), .ex_valid_o(ex_valid_o), .wb_valid_o(wb_valid_o),
    .id_kind_o(id_kind_o), .ex_kind_o(ex_kind_o),
    .kill_fetch_o(kill_fetch_o), .kill_dec_o(kill_dec_o), .bubble_cnt_o(bubble_cnt_o)
  );

  // behavioural reference: queue of three slots (decode, execute, writeback)
  logic [AW-1:0] m_pc;
  bit   m_v[3];
  int   m_k[3];
  int   m_cnt;
  bit   m_hv, m_ht;
  logic [AW-1:0] m_hb, m_hj;

  function automatic bit m_taken();
    return m_hv ? m_ht : br_taken_i;
  endfunction
  function automatic bit m_br();
    return m_v[1] && m_k[1] == 2 && m_taken();
  endfunction
  function automatic bit m_jmp();
    return m_v[0] && m_k[0] == 1 && !m_br();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = SPC; m_cnt = 0; m_hv = 0; m_ht = 0; m_hb = '0; m_hj = '0;
      for (int i = 0; i < 3; i++) begin m_v[i] = 0; m_k[i] = 0; end
    end else if (stall_i) begin
      if (!m_hv) begin
        m_hv = 1; m_ht = br_taken_i; m_hb = br_target_i; m_hj = jmp_target_i;
      end
    end else begin
      bit tb, tj;
      tb = m_br();
      tj = m_jmp();
      m_cnt = (m_cnt + ((ins_valid_i && (tb || tj)) ? 1 : 0) + ((m_v[0] && tb) ? 1 : 0)) % (1 << CW);
      if (tb)               m_pc = m_hv ? m_hb : br_target_i;
      else if (tj)          m_pc = m_hv ? m_hj : jmp_target_i;
      else if (ins_valid_i) m_pc = m_pc + 4;
      m_v[2] = m_v[1];           m_k[2] = m_k[1];
      m_v[1] = m_v[0] && !tb;    m_k[1] = m_k[0];
      m_v[0] = ins_valid_i && !(tb || tj); m_k[0] = ins_kind_i;
      m_hv = 0;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 fetch_pc", fetch_pc_o, m_pc);
    chk("R8 ready", ins_ready_o, !stall_i);
    chk("R7 id_valid", id_valid_o, m_v[0]);
    chk("R7 ex_valid", ex_valid_o, m_v[1]);
    chk("R7 wb_valid", wb_valid_o, m_v[2]);
    chk("R10 id_kind", id_kind_o, m_k[0]);
    chk("R10 ex_kind", ex_kind_o, m_k[1]);
    chk("R3 kill_fetch", kill_fetch_o, !stall_i && (m_br() || m_jmp()));
    chk("R4 kill_dec", kill_dec_o, !stall_i && m_br());
    chk("R11 bubble_cnt", bubble_cnt_o, m_cnt);
  endtask

  // apply inputs at the falling edge, compare, then let the rising edge act
  task automatic step(bit v, int k, bit tk, logic [AW-1:0] bt, logic [AW-1:0] jt, bit st);
    @(negedge clk);
    ins_valid_i = v; ins_kind_i = k[1:0]; br_taken_i = tk;
    br_target_i = bt; jmp_target_i = jt; stall_i = st;
    #1 compare_all();
    @(posedge clk);
    #1;
  endtask

  task automatic plains(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 32'h0, 32'h0, 0);
  endtask

  initial begin
    int c0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 pc", fetch_pc_o, SPC);
    chk("R1 valids", {id_valid_o, ex_valid_o, wb_valid_o}, 3'b000);
    chk("R1 count", bubble_cnt_o, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 pc after release", fetch_pc_o, SPC);

    // R2 sequential and empty slot
    plains(3);
    chk("R2 seq pc", fetch_pc_o, SPC + 12);
    step(0, 0, 0, 0, 0, 0);
    chk("R2 empty hold", fetch_pc_o, SPC + 12);

    // R3 jump penalty
    plains(3);
    c0 = bubble_cnt_o;
    step(1, 1, 0, 0, 32'h2000, 0);
    step(1, 0, 0, 0, 32'h2000, 0);
    chk("R3 jump target", fetch_pc_o, 32'h2000);
    chk("R3 id squashed", id_valid_o, 0);
    plains(3);
    chk("R3 jump penalty", (bubble_cnt_o - c0) & 4'hf, 1);

    // R4 taken branch penalty
    c0 = bubble_cnt_o;
    step(1, 2, 1, 32'h3000, 0, 0);
    step(1, 0, 1, 32'h3000, 0, 0);
    step(1, 0, 1, 32'h3000, 0, 0);
    chk("R4 branch target", fetch_pc_o, 32'h3000);
    chk("R4 both squashed", {id_valid_o, ex_valid_o}, 2'b00);
    plains(3);
    chk("R4 branch penalty", (bubble_cnt_o - c0) & 4'hf, 2);

    // R5 not-taken branch
    c0 = bubble_cnt_o;
    step(1, 2, 0, 32'h5000, 0, 0);
    plains(4);
    chk("R5 no penalty", (bubble_cnt_o - c0) & 4'hf, 0);
    chk("R5 sequential", fetch_pc_o, 32'h3000 + 12 + 20);

    // R6 branch beats jump
    c0 = bubble_cnt_o;
    step(1, 2, 1, 32'h6000, 32'h7000, 0);
    step(1, 1, 1, 32'h6000, 32'h7000, 0);
    step(1, 0, 1, 32'h6000, 32'h7000, 0);
    chk("R6 branch wins", fetch_pc_o, 32'h6000);
    plains(3);
    chk("R6 penalty", (bubble_cnt_o - c0) & 4'hf, 2);

    // R10 reserved kind acts as plain
    c0 = bubble_cnt_o;
    step(1, 3, 1, 32'h9000, 32'h9000, 0);
    plains(3);
    chk("R10 reserved no redirect", (bubble_cnt_o - c0) & 4'hf, 0);

    // R9 outcome held through stall
    step(1, 2, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 1, 32'h8000, 0, 1);
    chk("R8 frozen", ex_kind_o, 2);
    step(1, 0, 0, 32'h8800, 0, 1);
    step(1, 0, 0, 32'h8800, 0, 0);
    chk("R9 held target", fetch_pc_o, 32'h8000);

    // mixed traffic against the reference
    void'($urandom(7));
    for (int n = 0; n < 400; n++) begin
      int r, k;
      r = $urandom_range(0, 99);
      k = $urandom_range(0, 3);
      step(r < 85, k, $urandom_range(0, 1),
           32'h4000 + ($urandom_range(0, 255) << 2),
           32'hA000 + ($urandom_range(0, 255) << 2),
           $urandom_range(0, 99) < 15);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule